// File: doc/BRIEF.md
# Upward-Growing Stack Pointer with Limit and Floor Traps

This unit keeps the pointer of a word-aligned software stack in a 16-bit byte-addressed data memory. The stack grows toward higher addresses and the pointer always names the first free word. Single-word push and pop requests come in, along with two-word return frames for calls and exceptions. The unit forms each effective address from the pointer and performs the access on a small internal word RAM. It checks every such address against a software-written limit register and against a fixed floor.

An access whose address lies above the limit sets a sticky overflow flag. An access below the floor sets a sticky underflow flag. In either case the access is dropped and the pointer keeps its value. A call frame holds a 23-bit return address. An exception frame also carries the low status byte in the upper byte of its second word. A frame takes two cycles, and `busy` marks the second one.

Top module: `stkptr_unit`

## Requirements
- R1: After reset `sp` reads 0x0800, `limit` reads 0x0000, and `ovf_trap`, `unf_trap`, `busy` and `pop_valid` are all 0.
- R2: A push (`op_kind`=0) writes `push_data` at the address in `sp` and then raises `sp` by 2. A pop (`op_kind`=1) first lowers `sp` by 2 and reads at the new address. The read word appears on `pop_data` with `pop_valid`=1 in the cycle after the request, so data comes back last-in first-out. `sp` bit 0 is always 0.
- R3: A write through `lim_we` stores `lim_wdata` with bit 0 forced to 0. The new value takes effect from the next cycle. A stack access in the same cycle as the write is checked against the old limit.
- R4: An access whose effective address equals `limit` does not trap. An access whose effective address is greater than `limit` sets `ovf_trap`. This applies to pushes, to pops (effective address `sp`-2) and to frame words.
- R5: An access whose effective address is below 0x0800 sets `unf_trap`. For example, a pop while `sp` is 0x0800 has the effective address 0x07FE and sets the flag.
- R6: A trapping access writes nothing, produces no `pop_valid` and leaves `sp` unchanged. If the first word of a frame traps, the frame is abandoned.
- R7: `ovf_trap` and `unf_trap` stay set until `trap_clr` is pulsed. If a new trap and `trap_clr` occur in the same cycle, the flag ends up set.
- R8: A call (`op_kind`=2) pushes `ret_addr[15:0]` as the first word, then {9'b0, `ret_addr[22:16]`} as the second word, and raises `sp` by 4. `busy` is 1 during the cycle after the request.
- R9: An exception push (`op_kind`=3) uses the same frame as a call, except that the second word is {`sr_low`, 1'b0, `ret_addr[22:16]`}.
- R10: A request presented while `busy` is 1 is ignored: it changes neither `sp` nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Stack request strobe |
| op_kind | input | 2 | 0 push, 1 pop, 2 call frame, 3 exception frame |
| push_data | input | 16 | Word to push |
| ret_addr | input | 23 | Return address for frames |
| sr_low | input | 8 | Status byte for exception frames |
| lim_we | input | 1 | Limit register write strobe |
| lim_wdata | input | 16 | New limit value |
| trap_clr | input | 1 | Clears both trap flags |
| sp | output | 16 | Current stack pointer |
| limit | output | 16 | Current limit register |
| pop_data | output | 16 | Word read by the last pop |
| pop_valid | output | 1 | `pop_data` is valid this cycle |
| busy | output | 1 | Second frame word in progress |
| ovf_trap | output | 1 | Sticky overflow flag |
| unf_trap | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that `op_kind` is stable while `op_valid` is high and that reset is held for at least one clock edge. The bench drives every input on the falling edge and holds each request for exactly one cycle, except in the deliberate busy-overlap case. The bench writes the limit before any overflow check that depends on it; the one exception is the check of the reset value. The pointer stays inside the modelled RAM window in every test, so the address wrap-around in the RAM never aliases live stack words.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_CALL = 2'd2,
        OP_EXC  = 2'd3
    } stk_op_e;
endpackage

// File: rtl/stk_limit_reg.sv
module stk_limit_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] lim_q
);
    logic [AW-1:0] lim_d;

    always_comb begin
        lim_d = lim_q;
        if (we) begin
            lim_d = {wdata[AW-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lim_q <= '0;
        else        lim_q <= lim_d;
    end

    // R3: the stored limit is always word aligned
    assert_limit_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q[0] == 1'b0);

    // R3: a write is visible exactly one cycle later
    assert_limit_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> lim_q[AW-1:1] == $past(wdata[AW-1:1]));
endmodule

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
    parameter int          AW    = 16,
    parameter logic [15:0] FLOOR = 16'h0800
) (
    input  logic          valid,
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] lim,
    output logic          over_hit,
    output logic          under_hit
);
    localparam logic [AW-1:0] FLOOR_EA = AW'(FLOOR);

    always_comb begin
        over_hit  = valid && (ea > lim);
        under_hit = valid && (ea < FLOOR_EA);
    end
endmodule

// File: rtl/stk_word_ram.sv
module stk_word_ram #(
    parameter int DW    = 16,
    parameter int WORDS = 256,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [DW-1:0]   wdata,
    input  logic            re,
    input  logic [IDXW-1:0] ridx,
    output logic [DW-1:0]   rdata_q
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
        if (re) rdata_q <= mem[ridx];
    end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit #(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int          RA_W      = 23,
    parameter int          SRW       = 8,
    parameter int          RAM_WORDS = 256,
    parameter logic [15:0] FLOOR     = 16'h0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [DW-1:0]   push_data,
    input  logic [RA_W-1:0] ret_addr,
    input  logic [SRW-1:0]  sr_low,
    input  logic            lim_we,
    input  logic [AW-1:0]   lim_wdata,
    input  logic            trap_clr,
    output logic [AW-1:0]   sp,
    output logic [AW-1:0]   limit,
    output logic [DW-1:0]   pop_data,
    output logic            pop_valid,
    output logic            busy,
    output logic            ovf_trap,
    output logic            unf_trap
);
    import stk_pkg::*;

    localparam int HI_W = RA_W - DW;
    localparam int IDXW = $clog2(RAM_WORDS);
    localparam logic [AW-1:0] STEP  = AW'(2);
    localparam logic [AW-1:0] SP_RST = AW'(FLOOR);

    typedef struct packed {
        logic [AW-1:0] sp;
        logic          ovf;
        logic          unf;
        logic          pend;
        logic [DW-1:0] word1;
        logic          popv;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] lim_q;
    logic [AW-1:0] ea;
    logic          acc_valid, is_pop, ovf_hit, unf_hit, fault;
    logic          ram_we, ram_re;
    logic [DW-1:0] ram_wdata, frame_hi;
    stk_op_e       kind;

    stk_limit_reg #(.AW(AW)) u_limit (
        .clk(clk), .rst_n(rst_n), .we(lim_we), .wdata(lim_wdata), .lim_q(lim_q)
    );

    always_comb begin
        kind      = stk_op_e'(op_kind);
        acc_valid = st_q.pend || op_valid;
        is_pop    = !st_q.pend && op_valid && (kind == OP_POP);
        ea        = is_pop ? (st_q.sp - STEP) : st_q.sp;
    end

    stk_bound_chk #(.AW(AW), .FLOOR(FLOOR)) u_chk (
        .valid(acc_valid), .ea(ea), .lim(lim_q),
        .over_hit(ovf_hit), .under_hit(unf_hit)
    );

    always_comb begin
        frame_hi = '0;
        frame_hi[HI_W-1:0] = ret_addr[RA_W-1:DW];
        if (kind == OP_EXC) begin
            frame_hi[DW-1 -: SRW] = sr_low;
        end
    end

    always_comb begin
        fault     = ovf_hit || unf_hit;
        st_d      = st_q;
        st_d.popv = 1'b0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_wdata = '0;

        if (trap_clr) begin
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
        end
        if (ovf_hit) st_d.ovf = 1'b1;
        if (unf_hit) st_d.unf = 1'b1;

        if (st_q.pend) begin
            st_d.pend = 1'b0;
            if (!fault) begin
                ram_we    = 1'b1;
                ram_wdata = st_q.word1;
                st_d.sp   = st_q.sp + STEP;
            end
        end else if (op_valid && !fault) begin
            unique case (kind)
                OP_PUSH: begin
                    ram_we    = 1'b1;
                    ram_wdata = push_data;
                    st_d.sp   = st_q.sp + STEP;
                end
                OP_POP: begin
                    ram_re    = 1'b1;
                    st_d.sp   = ea;
                    st_d.popv = 1'b1;
                end
                OP_CALL, OP_EXC: begin
                    ram_we     = 1'b1;
                    ram_wdata  = ret_addr[DW-1:0];
                    st_d.sp    = st_q.sp + STEP;
                    st_d.pend  = 1'b1;
                    st_d.word1 = frame_hi;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sp: SP_RST, ovf: 1'b0, unf: 1'b0, pend: 1'b0,
                      word1: '0, popv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    stk_word_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
        .clk(clk), .we(ram_we), .widx(ea[IDXW:1]), .wdata(ram_wdata),
        .re(ram_re), .ridx(ea[IDXW:1]), .rdata_q(pop_data)
    );

    assign sp        = st_q.sp;
    assign limit     = lim_q;
    assign pop_valid = st_q.popv;
    assign busy      = st_q.pend;
    assign ovf_trap  = st_q.ovf;
    assign unf_trap  = st_q.unf;

    // R2: pointer stays word aligned
    assert_sp_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sp[0] == 1'b0);

    // R2: a clean single push advances the pointer by one word
    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !st_q.pend && kind == OP_PUSH && !fault)
        |=> st_q.sp == $past(st_q.sp) + STEP);

    // R4: an access exactly at the limit never reports overflow
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ea == lim_q) |-> !ovf_hit);

    // R4: the overflow flag rises only after a checked address above the limit
    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(ovf_hit));

    // R6: a faulting access leaves the pointer untouched
    assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && fault) |=> $stable(st_q.sp));

    // R7: flags hold while no clear is given
    assert_trap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ovf || st_q.unf) && !trap_clr)
        |=> (st_q.ovf >= $past(st_q.ovf)) && (st_q.unf >= $past(st_q.unf)));

    // R8: the second frame word occupies exactly one cycle
    assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> !st_q.pend);
endmodule

// File: tb/stkptr_unit_tb_top.sv
module stkptr_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [15:0] push_data = '0;
    logic [22:0] ret_addr = '0;
    logic [7:0]  sr_low = '0;
    logic        lim_we = 1'b0;
    logic [15:0] lim_wdata = '0;
    logic        trap_clr = 1'b0;
    logic [15:0] sp, limit, pop_data;
    logic        pop_valid, busy, ovf_trap, unf_trap;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stkptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .push_data(push_data), .ret_addr(ret_addr), .sr_low(sr_low),
        .lim_we(lim_we), .lim_wdata(lim_wdata), .trap_clr(trap_clr),
        .sp(sp), .limit(limit), .pop_data(pop_data), .pop_valid(pop_valid),
        .busy(busy), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; lim_we = 1'b0; trap_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_limit(input logic [15:0] v);
        @(negedge clk);
        lim_we = 1'b1; lim_wdata = v;
        @(negedge clk);
        lim_we = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] k, input logic [15:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; push_data = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [15:0] exp, input string tag);
        do_op(2'd1, 16'h0);
        check(pop_valid === 1'b1 && pop_data === exp, tag, pop_data, exp);
    endtask

    task automatic t_reset();
        do_reset();
        check(sp === 16'h0800, "R1 sp", sp, 16'h0800);
        check(limit === 16'h0000, "R1 limit", limit, 0);
        check({ovf_trap, unf_trap, busy, pop_valid} === 4'b0, "R1 flags",
              {ovf_trap, unf_trap, busy, pop_valid}, 0);
    endtask

    task automatic t_push_pop();
        do_reset();
        set_limit(16'h0FFE);
        do_op(2'd0, 16'hA1A1);
        do_op(2'd0, 16'hB2B2);
        do_op(2'd0, 16'hC3C3);
        check(sp === 16'h0806, "R2 sp after pushes", sp, 16'h0806);
        pop_expect(16'hC3C3, "R2 pop1");
        check(sp === 16'h0804, "R2 sp after pop", sp, 16'h0804);
        pop_expect(16'hB2B2, "R2 pop2");
        pop_expect(16'hA1A1, "R2 pop3");
        check(sp === 16'h0800, "R2 sp home", sp, 16'h0800);
        @(negedge clk);
        check(pop_valid === 1'b0, "R2 pop_valid one cycle", pop_valid, 0);
    endtask

    task automatic t_limit();
        do_reset();
        set_limit(16'h0901);
        check(limit === 16'h0900, "R3 bit0 forced", limit, 16'h0900);
        @(negedge clk);
        lim_we = 1'b1; lim_wdata = 16'h0700;
        op_valid = 1'b1; op_kind = 2'd0; push_data = 16'h1111;
        @(negedge clk);
        lim_we = 1'b0; op_valid = 1'b0;
        check(sp === 16'h0802 && !ovf_trap, "R3 old limit used", sp, 16'h0802);
        check(limit === 16'h0700, "R3 new limit", limit, 16'h0700);
        do_op(2'd0, 16'h2222);
        check(ovf_trap === 1'b1, "R3 new limit enforced", ovf_trap, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        set_limit(16'h0804);
        do_op(2'd0, 16'h0101);
        do_op(2'd0, 16'h0202);
        do_op(2'd0, 16'h0303);
        check(sp === 16'h0806 && !ovf_trap, "R4 push at limit no trap", sp, 16'h0806);
        do_op(2'd0, 16'h0404);
        check(ovf_trap === 1'b1, "R4 push past limit traps", ovf_trap, 1);
        check(sp === 16'h0806, "R6 sp held on fault", sp, 16'h0806);
        pop_expect(16'h0303, "R6 faulting write suppressed");
        set_limit(16'h0800);
        trap_clr = 1'b1; @(negedge clk); trap_clr = 1'b0;
        do_op(2'd1, 16'h0);
        check(ovf_trap === 1'b1 && pop_valid === 1'b0, "R4 pop above limit traps",
              ovf_trap, 1);
    endtask

    task automatic t_underflow();
        do_reset();
        set_limit(16'h0FFE);
        do_op(2'd1, 16'h0);
        check(unf_trap === 1'b1 && !ovf_trap, "R5 pop below floor", unf_trap, 1);
        check(sp === 16'h0800 && pop_valid === 1'b0, "R6 pop dropped", sp, 16'h0800);
    endtask

    task automatic t_sticky();
        do_op(2'd0, 16'h5555);
        check(unf_trap === 1'b1, "R7 unf holds", unf_trap, 1);
        @(negedge clk); trap_clr = 1'b1;
        @(negedge clk); trap_clr = 1'b0;
        check(unf_trap === 1'b0, "R7 cleared", unf_trap, 0);
        set_limit(16'h0800);
        @(negedge clk);
        trap_clr = 1'b1; op_valid = 1'b1; op_kind = 2'd0; push_data = 16'h6666;
        @(negedge clk);
        trap_clr = 1'b0; op_valid = 1'b0;
        check(ovf_trap === 1'b1, "R7 set wins over clear", ovf_trap, 1);
    endtask

    task automatic t_frame(input logic [1:0] k, input logic [22:0] ra,
                           input logic [7:0] s, input logic [15:0] hi, input string tag);
        do_reset();
        set_limit(16'h0FFE);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; ret_addr = ra; sr_low = s;
        @(negedge clk);
        op_valid = 1'b0;
        check(busy === 1'b1, {tag, " busy"}, busy, 1);
        @(negedge clk);
        check(busy === 1'b0 && sp === 16'h0804, {tag, " sp+4"}, sp, 16'h0804);
        pop_expect(hi, {tag, " high word"});
        pop_expect(ra[15:0], {tag, " low word"});
    endtask

    task automatic t_busy_ignore();
        do_reset();
        set_limit(16'h0FFE);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd2; ret_addr = 23'h012345;
        @(negedge clk);
        op_kind = 2'd0; push_data = 16'hDEAD;
        @(negedge clk);
        op_valid = 1'b0;
        check(sp === 16'h0804, "R10 sp ignores request", sp, 16'h0804);
        pop_expect(16'h0001, "R10 memory untouched");
    endtask

    initial begin
        t_reset();
        t_push_pop();
        t_limit();
        t_overflow();
        t_underflow();
        t_sticky();
        t_frame(2'd2, 23'h5A1234, 8'hC3, 16'h005A, "R8 call");
        t_frame(2'd3, 23'h7FABCD, 8'hC3, 16'hC37F, "R9 exception");
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule